// File: doc/BRIEF.md
# Clock Output Gate and Strap Latch

This block sits between the clock dividers of a system clock generator and its output pads. It receives one clock per source (the PCI-rate clock, the 33 MHz and 66 MHz candidates for the selectable outputs, the reference clock, the 48 MHz and 24 MHz clocks and the CPU clock). From these it drives six stoppable PCI outputs, one free-running PCI output, three selectable 33/66 MHz outputs, three reference outputs, a 48 MHz output, a 24/48 MHz output and two differential CPU pairs. Each output has an enable bit. The six stoppable PCI outputs also obey an active-low stop pin, and each of them has an override bit that exempts it from that pin.

Five pads are shared between strap inputs and clock outputs: the three reference outputs, the free-running PCI output and the 24/48 output. While the chip comes out of power-on reset, these pads are inputs. A single-cycle strobe marks the end of power-on reset. On the first strobe after reset the block captures the pad levels and the 33/66 select pin into latches. One cycle later it turns the shared pads into outputs and lets all clocks start. Later strobes are ignored.

Every gate decision passes through a two-stage synchronizer clocked on the falling edge of its own source clock. A gate therefore only opens or closes while that source is low, and every output pulse has the full width of a source high phase.

Top module: `clkout_gate`

## Requirements
- R1: An output whose enable bit is 0 is held at 0. Its gate follows a change of the enable bit at the second falling edge of that output's source clock after the change. An enabled output follows its source clock.
- R2: While `stop_n` is 0, each stoppable PCI output whose override bit is 0 is held at 0. The free-running PCI output `pcif_out` keeps following `pci_src`.
- R3: A stoppable PCI output whose override bit `free_pci[i]` is 1 keeps following `pci_src` while `stop_n` is 0.
- R4: From reset until one `sys_clk` cycle after the first `por_strobe`, `strap_oe` is 0 and every clock output is 0. No clock starts before `strap_oe` is 1.
- R5: For each CPU pair, `cpu_c[i]` is always the inverse of `cpu_t[i]`. A disabled pair parks with `cpu_t[i]`=0 and `cpu_c[i]`=1.
- R6: On the first cycle in which `por_strobe` is 1 after reset, `strap_q` captures the pads as follows: bits 2:0 take the inverted levels of `strap_pin[2:0]`, and bits 4:3 take `strap_pin[4:3]` unchanged. `strap_q` then holds until the next reset, whatever the pins and later strobes do.
- R7: `hs_sel_pin` is captured together with the straps. A captured 0 makes the three selectable outputs follow `sel66_src`; a captured 1 makes them follow `sel33_src`.
- R8: `strap_q[4]` selects the source of `f2448_out`: 0 selects `usb48_src` (48 MHz) and 1 selects `half24_src` (24 MHz).
- R9: A gate changes only while its source clock is low. Every high pulse of a gated output lasts exactly one source high phase, including across stop and restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Control clock for the strap logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_strobe | input | 1 | One-cycle end-of-power-on-reset strobe (sys_clk domain) |
| strap_pin | input | 5 | Levels read from the shared pads |
| hs_sel_pin | input | 1 | 33/66 select pin, captured at the strobe (0 = 66 MHz) |
| pci_src | input | 1 | PCI-rate source clock |
| sel33_src | input | 1 | 33 MHz candidate for the selectable outputs |
| sel66_src | input | 1 | 66 MHz candidate for the selectable outputs |
| ref_src | input | 1 | Reference source clock |
| usb48_src | input | 1 | 48 MHz source clock |
| half24_src | input | 1 | 24 MHz source clock |
| cpu_src | input | 1 | CPU source clock |
| stop_n | input | 1 | Active-low stop for the stoppable PCI outputs |
| en_pci | input | 6 | Enables of the stoppable PCI outputs |
| free_pci | input | 6 | Stop overrides of the stoppable PCI outputs |
| en_pcif | input | 1 | Enable of the free-running PCI output |
| en_sel | input | 3 | Enables of the selectable outputs |
| en_ref | input | 3 | Enables of the reference outputs |
| en_usb | input | 1 | Enable of the 48 MHz output |
| en_2448 | input | 1 | Enable of the 24/48 output |
| en_cpu | input | 2 | Enables of the CPU pairs |
| strap_oe | output | 1 | Output enable of the five shared pads |
| strap_q | output | 5 | Captured strap values |
| pci_out | output | 6 | Stoppable PCI outputs |
| pcif_out | output | 1 | Free-running PCI output |
| sel_out | output | 3 | Selectable 33/66 outputs |
| ref_out | output | 3 | Reference outputs |
| usb_out | output | 1 | 48 MHz output |
| f2448_out | output | 1 | 24/48 output |
| cpu_t | output | 2 | CPU pair true outputs |
| cpu_c | output | 2 | CPU pair complement outputs |

## Verification
A synchronizer stage that is stuck or skipped moves the start or end of an output's gating by one source falling edge. The per-cycle comparison sees this within one source period after any enable, stop or override change. A gate flop clocked on the wrong edge shows up at once as a shortened high pulse, which the pulse-width monitor measures. A wrong strap or select latch shows up on the first cycle after the strobe, either as a wrong `strap_q` readback or as a selectable or 24/48 output that follows the wrong source clock.

// File: rtl/clkout_gate.sv
module clkout_gate #(
  parameter int NPCI   = 6,
  parameter int NSEL   = 3,
  parameter int NREF   = 3,
  parameter int NCPU   = 2,
  parameter int NSTRAP = 5,
  parameter int NFS    = 3,
  parameter int SYNC   = 2
) (
  input  logic              sys_clk,
  input  logic              rst_n,
  input  logic              por_strobe,
  input  logic [NSTRAP-1:0] strap_pin,
  input  logic              hs_sel_pin,
  input  logic              pci_src,
  input  logic              sel33_src,
  input  logic              sel66_src,
  input  logic              ref_src,
  input  logic              usb48_src,
  input  logic              half24_src,
  input  logic              cpu_src,
  input  logic              stop_n,
  input  logic [NPCI-1:0]   en_pci,
  input  logic [NPCI-1:0]   free_pci,
  input  logic              en_pcif,
  input  logic [NSEL-1:0]   en_sel,
  input  logic [NREF-1:0]   en_ref,
  input  logic              en_usb,
  input  logic              en_2448,
  input  logic [NCPU-1:0]   en_cpu,
  output logic              strap_oe,
  output logic [NSTRAP-1:0] strap_q,
  output logic [NPCI-1:0]   pci_out,
  output logic              pcif_out,
  output logic [NSEL-1:0]   sel_out,
  output logic [NREF-1:0]   ref_out,
  output logic              usb_out,
  output logic              f2448_out,
  output logic [NCPU-1:0]   cpu_t,
  output logic [NCPU-1:0]   cpu_c
);
  localparam int NOUT   = NPCI + 1 + NSEL + NREF + 2 + NCPU;
  localparam int O_PCIF = NPCI;
  localparam int O_SEL  = O_PCIF + 1;
  localparam int O_REF  = O_SEL + NSEL;
  localparam int O_USB  = O_REF + NREF;
  localparam int O_F    = O_USB + 1;
  localparam int O_CPU  = O_F + 1;
  localparam logic [NSTRAP-1:0] FS_INV = NSTRAP'((1 << NFS) - 1);

  logic              taken_q, done_q, hs_q;
  logic [NSTRAP-1:0] strap_r;

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q <= 1'b0;
      done_q  <= 1'b0;
      hs_q    <= 1'b0;
      strap_r <= '0;
    end else begin
      done_q <= taken_q;
      if (por_strobe && !taken_q) begin
        taken_q <= 1'b1;
        strap_r <= strap_pin ^ FS_INV;
        hs_q    <= hs_sel_pin;
      end
    end
  end

  logic sel_ck, f_ck;
  assign sel_ck = hs_q ? sel33_src : sel66_src;
  assign f_ck   = strap_r[NSTRAP-1] ? half24_src : usb48_src;

  logic [NOUT-1:0] src_v, want_v, gate_v, clk_v;

  assign src_v  = {{NCPU{cpu_src}}, f_ck, usb48_src, {NREF{ref_src}},
                   {NSEL{sel_ck}}, pci_src, {NPCI{pci_src}}};
  assign want_v = {NOUT{done_q}} &
                  {en_cpu, en_2448, en_usb, en_ref, en_sel, en_pcif,
                   en_pci & (free_pci | {NPCI{stop_n}})};

  for (genvar i = 0; i < NOUT; i++) begin : g_gate
    logic [SYNC-1:0] sh;
    always_ff @(negedge src_v[i] or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC-2:0], want_v[i]};
    end
    assign gate_v[i] = sh[SYNC-1];
  end

  assign clk_v     = src_v & gate_v;
  assign pci_out   = clk_v[NPCI-1:0];
  assign pcif_out  = clk_v[O_PCIF];
  assign sel_out   = clk_v[O_SEL +: NSEL];
  assign ref_out   = clk_v[O_REF +: NREF];
  assign usb_out   = clk_v[O_USB];
  assign f2448_out = clk_v[O_F];
  assign cpu_t     = clk_v[O_CPU +: NCPU];
  assign cpu_c     = ~cpu_t;
  assign strap_oe  = done_q;
  assign strap_q   = strap_r;
endmodule

// File: rtl/clkout_gate_chk.sv
module clkout_gate_chk #(
  parameter int NPCI   = 6,
  parameter int NSEL   = 3,
  parameter int NREF   = 3,
  parameter int NCPU   = 2,
  parameter int NSTRAP = 5,
  parameter int NOUT   = 17
) (
  input logic              sys_clk,
  input logic              rst_n,
  input logic              pci_src,
  input logic              ref_src,
  input logic              cpu_src,
  input logic              stop_n,
  input logic              en_pcif,
  input logic              strap_oe,
  input logic [NPCI-1:0]   en_pci,
  input logic [NPCI-1:0]   free_pci,
  input logic [NPCI-1:0]   pci_out,
  input logic              pcif_out,
  input logic [NSEL-1:0]   sel_out,
  input logic [NREF-1:0]   en_ref,
  input logic [NREF-1:0]   ref_out,
  input logic              usb_out,
  input logic              f2448_out,
  input logic [NCPU-1:0]   en_cpu,
  input logic [NCPU-1:0]   cpu_t,
  input logic [NCPU-1:0]   cpu_c,
  input logic [NSTRAP-1:0] strap_q,
  input logic [NOUT-1:0]   src_v,
  input logic [NOUT-1:0]   gate_v
);
  logic [1:0] arm;
  always_ff @(negedge pci_src or negedge rst_n) begin
    if (!rst_n)          arm <= 2'd0;
    else if (arm != 2'd3) arm <= arm + 2'd1;
  end

  assert_pcif_runs_R2: assert property (@(negedge pci_src) disable iff (!rst_n)
    (arm[1] && $past(en_pcif && strap_oe, 2)) |-> pcif_out);

  for (genvar i = 0; i < NPCI; i++) begin : g_pci
    assert_stop_low_R2: assert property (@(negedge pci_src) disable iff (!rst_n)
      $past(!stop_n && !free_pci[i], 2) |-> !pci_out[i]);
    assert_free_runs_R3: assert property (@(negedge pci_src) disable iff (!rst_n)
      (arm[1] && $past(en_pci[i] && free_pci[i] && strap_oe, 2)) |-> pci_out[i]);
  end

  for (genvar i = 0; i < NREF; i++) begin : g_ref
    assert_off_low_R1: assert property (@(negedge ref_src) disable iff (!rst_n)
      $past(!en_ref[i], 2) |-> !ref_out[i]);
  end

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    assert_cpu_park_R5: assert property (@(negedge cpu_src) disable iff (!rst_n)
      $past(!en_cpu[i], 2) |-> (!cpu_t[i] && cpu_c[i]));
  end

  assert_quiet_before_oe_R4: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !strap_oe |-> (pci_out == '0 && !pcif_out && sel_out == '0 && ref_out == '0 &&
                   !usb_out && !f2448_out && cpu_t == '0));

  assert_strap_hold_R6: assert property (@(posedge sys_clk) disable iff (!rst_n)
    strap_oe |=> $stable(strap_q));

  for (genvar i = 0; i < NOUT; i++) begin : g_r9
    always @(gate_v[i]) begin
      if (rst_n) assert_gate_low_R9: assert (!src_v[i]);
    end
  end
endmodule

bind clkout_gate clkout_gate_chk #(
  .NPCI(NPCI), .NSEL(NSEL), .NREF(NREF), .NCPU(NCPU), .NSTRAP(NSTRAP), .NOUT(NOUT)
) u_chk (.*);

// File: tb/sim_clkout_gate.sv
`timescale 1ns/100ps
module sim_clkout_gate;
  logic sys_clk = 1'b0;
  always #10 sys_clk = ~sys_clk;

  logic pci_src = 0, sel33_src = 0, sel66_src = 0, ref_src = 0;
  logic usb48_src = 0, half24_src = 0, cpu_src = 0;
  initial begin #0.5; forever #15 pci_src    = ~pci_src;    end
  initial begin #1.5; forever #15 sel33_src  = ~sel33_src;  end
  initial begin #2.5; forever #7  sel66_src  = ~sel66_src;  end
  initial begin #3.5; forever #35 ref_src    = ~ref_src;    end
  initial begin #4.5; forever #10 usb48_src  = ~usb48_src;  end
  initial begin #5.5; forever #20 half24_src = ~half24_src; end
  initial begin #6.5; forever #5  cpu_src    = ~cpu_src;    end

  logic       rst_n, por_strobe, hs_sel_pin, stop_n, en_pcif, en_usb, en_2448;
  logic [4:0] strap_pin, strap_q;
  logic [5:0] en_pci, free_pci, pci_out;
  logic [2:0] en_sel, en_ref, sel_out, ref_out;
  logic [1:0] en_cpu, cpu_t, cpu_c;
  logic       strap_oe, pcif_out, usb_out, f2448_out;

  clkout_gate u0 (
    .sys_clk(sys_clk), .rst_n(rst_n), .por_strobe(por_strobe), .strap_pin(strap_pin),
    .hs_sel_pin(hs_sel_pin), .pci_src(pci_src), .sel33_src(sel33_src),
    .sel66_src(sel66_src), .ref_src(ref_src), .usb48_src(usb48_src),
    .half24_src(half24_src), .cpu_src(cpu_src), .stop_n(stop_n), .en_pci(en_pci),
    .free_pci(free_pci), .en_pcif(en_pcif), .en_sel(en_sel), .en_ref(en_ref),
    .en_usb(en_usb), .en_2448(en_2448), .en_cpu(en_cpu), .strap_oe(strap_oe),
    .strap_q(strap_q), .pci_out(pci_out), .pcif_out(pcif_out), .sel_out(sel_out),
    .ref_out(ref_out), .usb_out(usb_out), .f2448_out(f2448_out), .cpu_t(cpu_t),
    .cpu_c(cpu_c));

  int checks = 0, fails = 0;
  logic mon_en = 1'b0;

  task automatic cmp(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, got, exp);
    end
  endtask

  // reference model: strap capture, one-cycle output enable delay
  logic taken_m, done_m, hs_m;
  logic [4:0] strap_m;
  always @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_m <= 0; done_m <= 0; hs_m <= 0; strap_m <= 0;
    end else begin
      done_m <= taken_m;
      if (por_strobe && !taken_m) begin
        taken_m <= 1;
        strap_m <= {strap_pin[4], strap_pin[3], ~strap_pin[2], ~strap_pin[1], ~strap_pin[0]};
        hs_m    <= hs_sel_pin;
      end
    end
  end

  wire sel_ck_m = hs_m ? sel33_src : sel66_src;
  wire f_ck_m   = strap_m[4] ? half24_src : usb48_src;

  // decision history per domain: second falling edge takes effect
  logic [6:0] p1, p2;
  logic [2:0] s1, s2, r1, r2;
  logic       u1, u2, f1, f2;
  logic [1:0] c1, c2;
  always @(negedge pci_src or negedge rst_n)
    if (!rst_n) begin p1 <= 0; p2 <= 0; end
    else begin
      p2 <= p1;
      p1 <= {done_m & en_pcif, {6{done_m}} & en_pci & (free_pci | {6{stop_n}})};
    end
  always @(negedge sel_ck_m or negedge rst_n)
    if (!rst_n) begin s1 <= 0; s2 <= 0; end
    else begin s2 <= s1; s1 <= {3{done_m}} & en_sel; end
  always @(negedge ref_src or negedge rst_n)
    if (!rst_n) begin r1 <= 0; r2 <= 0; end
    else begin r2 <= r1; r1 <= {3{done_m}} & en_ref; end
  always @(negedge usb48_src or negedge rst_n)
    if (!rst_n) begin u1 <= 0; u2 <= 0; end
    else begin u2 <= u1; u1 <= done_m & en_usb; end
  always @(negedge f_ck_m or negedge rst_n)
    if (!rst_n) begin f1 <= 0; f2 <= 0; end
    else begin f2 <= f1; f1 <= done_m & en_2448; end
  always @(negedge cpu_src or negedge rst_n)
    if (!rst_n) begin c1 <= 0; c2 <= 0; end
    else begin c2 <= c1; c1 <= {2{done_m}} & en_cpu; end

  always @(negedge sys_clk) begin
    if (mon_en) begin
      cmp("R2 stoppable pci", {26'd0, pci_out}, {26'd0, {6{pci_src}} & p2[5:0]});
      cmp("R2 free-running pci", {31'd0, pcif_out}, {31'd0, pci_src & p2[6]});
      cmp("R7 selectable", {29'd0, sel_out}, {29'd0, {3{sel_ck_m}} & s2});
      cmp("R1 reference", {29'd0, ref_out}, {29'd0, {3{ref_src}} & r2});
      cmp("R1 usb48", {31'd0, usb_out}, {31'd0, usb48_src & u2});
      cmp("R8 f2448", {31'd0, f2448_out}, {31'd0, f_ck_m & f2});
      cmp("R5 cpu pairs", {28'd0, cpu_t, cpu_c},
          {28'd0, {2{cpu_src}} & c2, ~({2{cpu_src}} & c2)});
      cmp("R4 strap_oe", {31'd0, strap_oe}, {31'd0, done_m});
      cmp("R6 strap_q", {27'd0, strap_q}, {27'd0, strap_m});
    end
  end

  // R9 pulse width monitor on one stoppable output
  realtime rise_t = 0.0;
  int pulses = 0, bad_pulses = 0;
  always @(posedge pci_out[2]) rise_t = $realtime;
  always @(negedge pci_out[2]) begin
    if (mon_en && rst_n) begin
      pulses++;
      if (($realtime - rise_t) < 14.9 || ($realtime - rise_t) > 15.1) bad_pulses++;
    end
  end

  task automatic finish_up;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_up();
  end

  task automatic strobe;
    por_strobe = 1'b1;
    @(negedge sys_clk);
    por_strobe = 1'b0;
  endtask

  initial begin
    logic s_pcif, s_p0, s_p1, s_t1, s_c1low, s_r1;
    rst_n = 0; por_strobe = 0; hs_sel_pin = 0; stop_n = 1;
    strap_pin = 5'b10110;
    en_pci = 6'h3f; free_pci = 6'h00; en_pcif = 1; en_sel = 3'b111; en_ref = 3'b111;
    en_usb = 1; en_2448 = 1; en_cpu = 2'b11;
    repeat (6) @(negedge sys_clk);
    mon_en = 1'b1;
    rst_n = 1'b1;
    repeat (4) @(negedge sys_clk);
    cmp("R4 outputs quiet before strobe", {25'd0, strap_oe, pci_out}, 32'd0);

    strobe();
    repeat (3) @(negedge sys_clk);
    cmp("R6 strap capture inverted fs", {27'd0, strap_q}, 32'b10001);
    cmp("R4 strap_oe after strobe", {31'd0, strap_oe}, 32'd1);

    strap_pin = 5'b01001; hs_sel_pin = 1'b1;
    strobe();
    repeat (3) @(negedge sys_clk);
    cmp("R6 second strobe ignored", {27'd0, strap_q}, 32'b10001);
    repeat (20) @(negedge sys_clk);

    stop_n = 1'b0;
    repeat (6) @(negedge sys_clk);
    s_pcif = 0; s_p1 = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge sys_clk);
      s_pcif |= pcif_out; s_p1 |= pci_out[1];
    end
    cmp("R2 pcif runs during stop", {31'd0, s_pcif}, 32'd1);
    cmp("R2 pci1 held low during stop", {31'd0, s_p1}, 32'd0);

    free_pci = 6'b000101;
    repeat (6) @(negedge sys_clk);
    s_p0 = 0; s_p1 = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge sys_clk);
      s_p0 |= pci_out[0]; s_p1 |= pci_out[1];
    end
    cmp("R3 overridden pci0 runs", {31'd0, s_p0}, 32'd1);
    cmp("R3 pci1 still stopped", {31'd0, s_p1}, 32'd0);
    stop_n = 1'b1; free_pci = 6'h00;
    repeat (20) @(negedge sys_clk);

    en_cpu = 2'b01; en_ref = 3'b101; en_usb = 0; en_sel = 3'b011; en_2448 = 0;
    repeat (10) @(negedge sys_clk);
    s_t1 = 0; s_c1low = 0; s_r1 = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge sys_clk);
      s_t1 |= cpu_t[1]; s_c1low |= ~cpu_c[1]; s_r1 |= ref_out[1];
    end
    cmp("R5 disabled pair true low", {31'd0, s_t1}, 32'd0);
    cmp("R5 disabled pair comp high", {31'd0, s_c1low}, 32'd0);
    cmp("R1 disabled ref held low", {31'd0, s_r1}, 32'd0);
    en_cpu = 2'b11; en_ref = 3'b111; en_usb = 1; en_sel = 3'b111; en_2448 = 1;
    repeat (10) @(negedge sys_clk);

    for (int k = 0; k < 24; k++) begin
      en_pci = 6'(k * 11 + 5);
      stop_n = k[1];
      repeat (1 + k % 3) @(negedge sys_clk);
    end
    en_pci = 6'h3f; stop_n = 1'b1;
    repeat (10) @(negedge sys_clk);

    rst_n = 1'b0;
    strap_pin = 5'b01110; hs_sel_pin = 1'b1;
    repeat (6) @(negedge sys_clk);
    rst_n = 1'b1;
    repeat (2) @(negedge sys_clk);
    strobe();
    repeat (3) @(negedge sys_clk);
    cmp("R6 strap capture after second reset", {27'd0, strap_q}, 32'b01001);
    repeat (40) @(negedge sys_clk);

    cmp("R9 full-width pulses", {31'd0, (pulses > 10 && bad_pulses == 0)}, 32'd1);
    finish_up();
  end
endmodule